// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block steps a 32-bit load/store processor through its work one phase per clock. Each instruction moves through a short series of named states: fetch, decode, and then one or more states that depend on the instruction type. In each state at most one major unit (memory, register file or ALU) does useful work. The control lines depend only on the current state. The one exception is the branch PC load, which is qualified by the ALU zero flag outside the state machine.

The sequencer is delivered together with a compact datapath so that it can be exercised at its pins. That datapath holds the PC, the instruction register, the operand latches A and B, the ALU result latch and the memory data latch, plus a register file, an ALU and an ALU function decoder. One external memory port serves both instruction fetch and data access, and its read data arrives in the same cycle as the address. The state code, the PC and the register-file write port are exposed for observation.

The supported instructions are R-type (add, subtract, and, or, set-less-than), load word, store word and branch-on-equal. A branch finishes in 3 cycles, an R-type or store in 4, and a load in 5.

States and their codes:
- FETCH = 0
- DECODE = 1
- MEM_ADDR = 2
- MEM_READ = 3
- LOAD_WB = 4
- MEM_WRITE = 5
- EXEC = 6
- R_DONE = 7
- BRANCH = 8

Transitions:
- FETCH goes to DECODE.
- DECODE goes to MEM_ADDR for a load or store, to EXEC for an R-type, to BRANCH for a branch, and to FETCH for any other opcode.
- MEM_ADDR goes to MEM_READ for a load and to MEM_WRITE for a store.
- MEM_READ goes to LOAD_WB.
- LOAD_WB, MEM_WRITE, R_DONE and BRANCH go to FETCH.

Top module: `mcyc_sequencer`

## Requirements
- R1: A synchronous reset that is high at a rising edge puts the machine in FETCH (code 0), sets the PC to 0 and clears every general register to 0.
- R2: In FETCH, memory is read at the PC and the word is latched as the current instruction. The PC becomes PC+4 at the end of the cycle, and the next state is DECODE.
- R3: Opcodes are decoded from instruction bits [31:26]: R-type 6'b000000, load 6'b100011, store 6'b101011, branch 6'b000100. The state code sequences are 0,1,2,3,4 for a load; 0,1,2,5 for a store; 0,1,6,7 for an R-type; and 0,1,8 for a branch.
- R4: An R-type instruction selects its operation from bits [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. The result of rs (bits [25:21]) and rt (bits [20:16]) is written to rd (bits [15:11]) in its fourth cycle.
- R5: A load reads memory at rs plus the sign-extended bits [15:0] and writes that word to register rt in its fifth cycle.
- R6: A store writes register rt to memory at rs plus the sign-extended bits [15:0]. Its fourth cycle is the only cycle with a memory write enable.
- R7: When rs equals rt, a branch sets the PC to (address of branch + 4) + (sign-extended bits [15:0] shifted left by 2). Otherwise the PC stays at the branch address + 4. A branch writes neither registers nor memory.
- R8: An unknown opcode returns the machine to FETCH after DECODE, two cycles in total, with no register or memory write.
- R9: Register 0 always reads as zero, even after an instruction has written to it.
- R10: The register-file write enable is high only in R_DONE and LOAD_WB. Memory read and write are never enabled together. The PC changes only at the end of FETCH or of BRANCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 32 | Read data of the shared memory, valid in the same cycle as the address |
| mem_addr | output | 32 | Byte address: the PC in FETCH, the latched ALU result in data states |
| mem_wdata | output | 32 | Store data, taken from operand latch B |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable, which takes effect at the rising edge that ends the cycle |
| pc_o | output | 32 | Current program counter |
| step_o | output | 4 | Current state code |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |

## Verification
On every cycle the checker enforces several properties:
- The state that follows reset is FETCH with the PC at 0.
- FETCH always advances the PC by four and always leads to DECODE.
- LOAD_WB is reached only from MEM_READ, and BRANCH always ends in FETCH.
- Register writes appear only in the two completion states, and memory writes only in MEM_WRITE.
- Memory read and write are never enabled together, and the PC stays still outside FETCH and BRANCH.

Data values can only be shown by the bench's program. That covers ALU results for each function code, the load and store addresses and data, taken and not-taken branch targets in both directions, the hard-wired zero register, the unknown-opcode escape, and register clearing on reset.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_MEM_ADDR  = 4'd2,
        ST_MEM_READ  = 4'd3,
        ST_LOAD_WB   = 4'd4,
        ST_MEM_WRITE = 4'd5,
        ST_EXEC      = 4'd6,
        ST_R_DONE    = 4'd7,
        ST_BRANCH    = 4'd8
    } step_t;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;

    typedef enum logic [1:0] {
        BSEL_REG  = 2'd0,
        BSEL_FOUR = 2'd1,
        BSEL_IMM  = 2'd2,
        BSEL_BOFS = 2'd3
    } bsel_t;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'd0,
        AOP_SUB   = 2'd1,
        AOP_FUNCT = 2'd2
    } aluop_t;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_SLT = 3'd4
    } alufn_t;

    typedef struct packed {
        logic   pc_wr;
        logic   pc_wr_cond;
        logic   ir_wr;
        logic   ab_wr;
        logic   aluout_wr;
        logic   mdr_wr;
        logic   mem_rd;
        logic   mem_wr;
        logic   addr_from_alu;
        logic   rf_we;
        logic   dst_rd;
        logic   wb_mdr;
        logic   a_from_reg;
        bsel_t  b_sel;
        aluop_t alu_op;
    } ctl_t;

endpackage

// File: rtl/mcyc_fsm.sv
module mcyc_fsm
    import mcyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    output step_t      state,
    output ctl_t       ctl
);

    step_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH:    nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = ST_MEM_ADDR;
                else if (opcode == OPC_RTYPE)                  nxt = ST_EXEC;
                else if (opcode == OPC_BEQ)                    nxt = ST_BRANCH;
                else                                           nxt = ST_FETCH;
            end
            ST_MEM_ADDR: nxt = (opcode == OPC_LOAD) ? ST_MEM_READ : ST_MEM_WRITE;
            ST_MEM_READ: nxt = ST_LOAD_WB;
            ST_EXEC:     nxt = ST_R_DONE;
            default:     nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_wr  = 1'b1;
                ctl.b_sel  = BSEL_FOUR;
                ctl.alu_op = AOP_ADD;
                ctl.pc_wr  = 1'b1;
            end
            ST_DECODE: begin
                ctl.ab_wr     = 1'b1;
                ctl.b_sel     = BSEL_BOFS;
                ctl.alu_op    = AOP_ADD;
                ctl.aluout_wr = 1'b1;
            end
            ST_MEM_ADDR: begin
                ctl.a_from_reg = 1'b1;
                ctl.b_sel      = BSEL_IMM;
                ctl.alu_op     = AOP_ADD;
                ctl.aluout_wr  = 1'b1;
            end
            ST_MEM_READ: begin
                ctl.mem_rd        = 1'b1;
                ctl.addr_from_alu = 1'b1;
                ctl.mdr_wr        = 1'b1;
            end
            ST_LOAD_WB: begin
                ctl.rf_we  = 1'b1;
                ctl.wb_mdr = 1'b1;
            end
            ST_MEM_WRITE: begin
                ctl.mem_wr        = 1'b1;
                ctl.addr_from_alu = 1'b1;
            end
            ST_EXEC: begin
                ctl.a_from_reg = 1'b1;
                ctl.b_sel      = BSEL_REG;
                ctl.alu_op     = AOP_FUNCT;
                ctl.aluout_wr  = 1'b1;
            end
            ST_R_DONE: begin
                ctl.rf_we  = 1'b1;
                ctl.dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                ctl.a_from_reg = 1'b1;
                ctl.b_sel      = BSEL_REG;
                ctl.alu_op     = AOP_SUB;
                ctl.pc_wr_cond = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mcyc_aluctl.sv
module mcyc_aluctl
    import mcyc_pkg::*;
(
    input  aluop_t     op,
    input  logic [5:0] funct,
    output alufn_t     fn
);

    always_comb begin
        fn = FN_ADD;
        unique case (op)
            AOP_SUB:   fn = FN_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    6'h22:   fn = FN_SUB;
                    6'h24:   fn = FN_AND;
                    6'h25:   fn = FN_OR;
                    6'h2A:   fn = FN_SLT;
                    default: fn = FN_ADD;
                endcase
            end
            default:   fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
    import mcyc_pkg::*;
#(
    parameter int W = 32
) (
    input  alufn_t       fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (fn)
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    localparam int NREG = 1 << AW;

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
    import mcyc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] pc_o,
    output logic [3:0]        step_o,
    output logic              rf_we_o,
    output logic [REG_AW-1:0] rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o
);

    localparam int IMM_W = 16;

    step_t             state;
    ctl_t              ctl;
    alufn_t            fn;
    logic [DATA_W-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
    logic [DATA_W-1:0] rs_val, rt_val, imm_ext, alu_a, alu_b, alu_y;
    logic              alu_zero, pc_en;

    mcyc_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir_q[31:26]),
        .state  (state),
        .ctl    (ctl)
    );

    mcyc_aluctl u_aluctl (
        .op    (ctl.alu_op),
        .funct (ir_q[5:0]),
        .fn    (fn)
    );

    mcyc_alu #(.W(DATA_W)) u_alu (
        .fn   (fn),
        .a    (alu_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    mcyc_regfile #(.W(DATA_W), .AW(REG_AW)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ir_q[25:21]),
        .ra2 (ir_q[20:16]),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (ctl.rf_we),
        .wa  (rf_waddr_o),
        .wd  (rf_wdata_o)
    );

    assign imm_ext = {{(DATA_W-IMM_W){ir_q[15]}}, ir_q[15:0]};
    assign alu_a   = ctl.a_from_reg ? a_q : pc_q;

    always_comb begin
        unique case (ctl.b_sel)
            BSEL_FOUR: alu_b = DATA_W'(4);
            BSEL_IMM:  alu_b = imm_ext;
            BSEL_BOFS: alu_b = imm_ext << 2;
            default:   alu_b = b_q;
        endcase
    end

    assign pc_en = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
            mdr_q    <= '0;
        end else begin
            if (pc_en)         pc_q     <= ctl.pc_wr ? alu_y : aluout_q;
            if (ctl.ir_wr)     ir_q     <= mem_rdata;
            if (ctl.ab_wr)     a_q      <= rs_val;
            if (ctl.ab_wr)     b_q      <= rt_val;
            if (ctl.aluout_wr) aluout_q <= alu_y;
            if (ctl.mdr_wr)    mdr_q    <= mem_rdata;
        end
    end

    assign mem_addr   = ctl.addr_from_alu ? aluout_q : pc_q;
    assign mem_wdata  = b_q;
    assign mem_rd_en  = ctl.mem_rd;
    assign mem_wr_en  = ctl.mem_wr;
    assign pc_o       = pc_q;
    assign step_o     = state;
    assign rf_we_o    = ctl.rf_we;
    assign rf_waddr_o = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];
    assign rf_wdata_o = ctl.wb_mdr ? mdr_q : aluout_q;

endmodule

// File: rtl/mcyc_sequencer_chk.sv
module mcyc_sequencer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        step,
    input logic [DATA_W-1:0] pc,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              rf_we
);

    localparam logic [3:0] S_FETCH  = 4'd0;
    localparam logic [3:0] S_DECODE = 4'd1;
    localparam logic [3:0] S_MRD    = 4'd3;
    localparam logic [3:0] S_LWB    = 4'd4;
    localparam logic [3:0] S_MWR    = 4'd5;
    localparam logic [3:0] S_RDONE  = 4'd7;
    localparam logic [3:0] S_BR     = 4'd8;

    AST_RESET_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (step == S_FETCH && pc == '0));                           // R1
    AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        step == S_FETCH |=> pc == $past(pc) + DATA_W'(4));                      // R2
    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        step == S_FETCH |=> step == S_DECODE);                                  // R2
    AST_WB_AFTER_MEMRD: assert property (@(posedge clk) disable iff (rst)
        step == S_LWB |-> $past(step) == S_MRD);                                // R3
    AST_STORE_ONLY_MWR: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> step == S_MWR);                                              // R6
    AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (rst)
        step == S_BR |=> step == S_FETCH);                                      // R7
    AST_RF_WE_STATES: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (step == S_RDONE || step == S_LWB));                          // R10
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));                                                   // R10
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step != S_FETCH && step != S_BR) |=> $stable(pc));                    // R10

endmodule

bind mcyc_sequencer mcyc_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .step   (step_o),
    .pc     (pc_o),
    .mem_rd (mem_rd_en),
    .mem_wr (mem_wr_en),
    .rf_we  (rf_we_o)
);

// File: tb/tb_mcyc_sequencer.sv
`timescale 1ns/1ps
module tb_mcyc_sequencer;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] mem_rdata, mem_addr, mem_wdata, pc_o, rf_wdata_o;
    logic        mem_rd_en, mem_wr_en, rf_we_o;
    logic [3:0]  step_o;
    logic [4:0]  rf_waddr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] mem [64];

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) if (mem_wr_en) mem[mem_addr[7:2]] <= mem_wdata;

    mcyc_sequencer dut (
        .clk        (clk),
        .rst        (rst),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .pc_o       (pc_o),
        .step_o     (step_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o)
    );

    // kind: 0 no write, 1 register write, 2 memory store
    typedef struct packed {
        logic [31:0] pc;
        logic [3:0]  cyc;
        logic [19:0] seq;
        logic [1:0]  kind;
        logic [31:0] addr;
        logic [31:0] data;
        logic [47:0] tag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{32'd0,  4'd5, 20'h01234, 2'd1, 32'd1,   32'h0000_0011, "R5 lw "},
        '{32'd4,  4'd5, 20'h01234, 2'd1, 32'd2,   32'hFFFF_FFF0, "R5 lw "},
        '{32'd8,  4'd4, 20'h00167, 2'd1, 32'd3,   32'h0000_0001, "R4 add"},
        '{32'd12, 4'd4, 20'h00167, 2'd1, 32'd4,   32'h0000_0021, "R4 sub"},
        '{32'd16, 4'd4, 20'h00167, 2'd1, 32'd5,   32'h0000_0010, "R4 and"},
        '{32'd20, 4'd4, 20'h00167, 2'd1, 32'd6,   32'hFFFF_FFF1, "R4 or "},
        '{32'd24, 4'd4, 20'h00167, 2'd1, 32'd7,   32'h0000_0001, "R4 slt"},
        '{32'd28, 4'd4, 20'h00125, 2'd2, 32'd136, 32'h0000_0021, "R6 sw "},
        '{32'd32, 4'd3, 20'h00018, 2'd0, 32'd0,   32'd0,         "R7 bnt"},
        '{32'd36, 4'd3, 20'h00018, 2'd0, 32'd0,   32'd0,         "R7 btk"},
        '{32'd48, 4'd4, 20'h00167, 2'd1, 32'd0,   32'h0000_0022, "R9 wr0"},
        '{32'd52, 4'd4, 20'h00167, 2'd1, 32'd8,   32'h0000_0011, "R9 rd0"},
        '{32'd56, 4'd2, 20'h00001, 2'd0, 32'd0,   32'd0,         "R8 unk"},
        '{32'd60, 4'd5, 20'h01234, 2'd1, 32'd9,   32'h0000_0021, "R6 ld "},
        '{32'd64, 4'd3, 20'h00018, 2'd0, 32'd0,   32'd0,         "R7 bbk"},
        '{32'd64, 4'd3, 20'h00018, 2'd0, 32'd0,   32'd0,         "R7 bbk"}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // runs one instruction starting at a FETCH cycle; sampled at negedges
    task automatic run_one(input vec_t v);
        int          cyc = 0;
        int          nrf = 0;
        int          nst = 0;
        logic [19:0] seq = '0;
        logic [31:0] wa = '0, wd = '0, sa = '0, sd = '0;
        chk(step_o == 4'd0 && pc_o == v.pc, {v.tag, " R2 fetch pc"}, pc_o, v.pc);
        chk(mem_rd_en && !mem_wr_en && mem_addr == v.pc, {v.tag, " R2 fetch addr"}, mem_addr, v.pc);
        do begin
            seq = {seq[15:0], step_o};
            if (rf_we_o) begin nrf++; wa = 32'(rf_waddr_o); wd = rf_wdata_o; end
            if (mem_wr_en) begin nst++; sa = mem_addr; sd = mem_wdata; end
            cyc++;
            @(negedge clk);
        end while (step_o != 4'd0 && cyc < 10);
        chk(cyc == int'(v.cyc), {v.tag, " R3 cycles"}, 32'(cyc), 32'(v.cyc));
        chk(seq == v.seq, {v.tag, " R3 states"}, 32'(seq), 32'(v.seq));
        chk(nrf == (v.kind == 2'd1 ? 1 : 0), {v.tag, " R10 rf writes"}, 32'(nrf), 32'(v.kind == 2'd1));
        chk(nst == (v.kind == 2'd2 ? 1 : 0), {v.tag, " R6 mem writes"}, 32'(nst), 32'(v.kind == 2'd2));
        if (v.kind == 2'd1) chk(wa == v.addr && wd == v.data, {v.tag, " reg write"}, wd, v.data);
        if (v.kind == 2'd2) chk(sa == v.addr && sd == v.data, {v.tag, " store"}, sd, v.data);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] <= 32'h0;
        mem[0]  <= 32'h8C01_0080; // lw  r1,128(r0)
        mem[1]  <= 32'h8C02_0084; // lw  r2,132(r0)
        mem[2]  <= 32'h0022_1820; // add r3,r1,r2
        mem[3]  <= 32'h0022_2022; // sub r4,r1,r2
        mem[4]  <= 32'h0022_2824; // and r5,r1,r2
        mem[5]  <= 32'h0022_3025; // or  r6,r1,r2
        mem[6]  <= 32'h0041_382A; // slt r7,r2,r1
        mem[7]  <= 32'hAC04_0088; // sw  r4,136(r0)
        mem[8]  <= 32'h1022_0005; // beq r1,r2 (not taken)
        mem[9]  <= 32'h1067_0002; // beq r3,r7 -> 48
        mem[10] <= 32'h0000_4020; // skipped
        mem[12] <= 32'h0021_0020; // add r0,r1,r1
        mem[13] <= 32'h0001_4025; // or  r8,r0,r1
        mem[14] <= 32'hFC00_0000; // unknown opcode
        mem[15] <= 32'h8C09_0088; // lw  r9,136(r0)
        mem[16] <= 32'h1000_FFFF; // beq r0,r0 -> 64
        mem[32] <= 32'h0000_0011;
        mem[33] <= 32'hFFFF_FFF0;

        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(step_o == 4'd0, "R1 reset state", 32'(step_o), 32'd0);
        chk(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_one(VEC[i]);

        // reset taken mid-instruction
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(step_o == 4'd0 && pc_o == 32'd0, "R1 mid-run reset", pc_o, 32'd0);
        chk(!rf_we_o && !mem_wr_en, "R1 no write after reset", 32'(rf_we_o), 32'd0);

        // registers cleared by reset: or r10,r1,r0 must yield zero
        mem[0] <= 32'h0020_5025;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_one('{32'd0, 4'd4, 20'h00167, 2'd1, 32'd10, 32'd0, "R1 clr"});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule